// File: doc/BRIEF.md
# Device Slot ID Allocator

This block keeps track of which of 32 device slot numbers on a single bus are taken. It answers three kinds of request: take the lowest-numbered free slot, take one named slot, or give a slot back. A request is a single-cycle pulse on one of three request inputs, with an index input for the named forms. The answer arrives one cycle later as a valid pulse, a 2-bit status code and a 5-bit slot index.

Slot 0 belongs to the host bridge. It is marked taken when reset ends, so the first allocation returns slot 1. An index at or above 32 is rejected as out of range. A cycle that carries more than one request is rejected and leaves every slot as it was.

Top module: `slot_alloc_top`

## Requirements
- R1: The block tracks exactly 32 slots with indices 0 to 31; index 31 is a valid slot and any request index of 32 or more is out of range.
- R2: After reset slot 0 is occupied and slots 1 to 31 are free, and no response is issued until a request arrives.
- R3: An allocate request takes the free slot with the lowest index, marks it occupied and answers status OK (0) with that index.
- R4: An allocate request when all 32 slots are occupied answers status NONE_FREE (1) with index 0 and changes no slot.
- R5: A claim of an index of 32 or more answers status INVALID (2) with index 0 and changes no slot.
- R6: A claim of an occupied valid index answers status IN_USE (3) with index 0 and changes no slot; a claim of a free valid index marks it occupied and answers OK with that index.
- R7: A release of an index of 32 or more answers INVALID with index 0; a release of a valid index clears that slot, whether or not it was occupied, and answers OK with that index.
- R8: Every single request gets exactly one response, one clock cycle after the request; a cycle with no request produces no response in the following cycle.
- R9: A cycle with more than one request input high performs no operation and answers INVALID with index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request the lowest free slot |
| claim_req | input | 1 | Request the slot named by req_idx |
| release_req | input | 1 | Free the slot named by req_idx |
| req_idx | input | 8 | Slot index for claim and release |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 0 OK, 1 NONE_FREE, 2 INVALID, 3 IN_USE |
| rsp_idx | output | 5 | Slot index of the response, 0 on error |

## Verification
The occupancy bitmap is not visible at the ports, so a wrong bit shows up only when a later request reads it. A bit stuck high makes an allocation skip that slot or a claim of it return IN_USE. A bit stuck low makes the same slot come back twice. The bench therefore follows every change of a slot with a claim or an allocation that depends on it, so a corrupted bit is seen in the next response or within a few requests. It also fills the table completely, so the full-table path and the scan across all 32 positions are both exercised.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_NONE_FREE = 2'd1,
    ST_INVALID   = 2'd2,
    ST_IN_USE    = 2'd3
  } slot_status_e;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_CLAIM   = 3'd2,
    OP_RELEASE = 3'd3,
    OP_MULTI   = 3'd4
  } slot_op_e;

  // Count of raised request lines.
  function automatic int unsigned req_count(input logic a, input logic c, input logic r);
    return int'(a) + int'(c) + int'(r);
  endfunction

  // True when an index names an existing slot.
  function automatic logic idx_in_range(input int unsigned idx, input int unsigned num_slots);
    return idx < num_slots;
  endfunction

endpackage

// File: rtl/slot_req_decode.sv
module slot_req_decode
  import slot_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int REQ_W     = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             alloc_req,
  input  logic             claim_req,
  input  logic             release_req,
  input  logic [REQ_W-1:0] req_idx,
  output slot_op_e         op,
  output logic             in_range,
  output logic [IDX_W-1:0] slot_idx
);

  always_comb begin
    in_range = idx_in_range(int'(req_idx), NUM_SLOTS);
    slot_idx = req_idx[IDX_W-1:0];
    if (req_count(alloc_req, claim_req, release_req) > 1) op = OP_MULTI;
    else if (alloc_req)   op = OP_ALLOC;
    else if (claim_req)   op = OP_CLAIM;
    else if (release_req) op = OP_RELEASE;
    else                  op = OP_IDLE;
  end

endmodule

// File: rtl/slot_lowest_free.sv
module slot_lowest_free #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] occ,
  output logic                 found,
  output logic [IDX_W-1:0]     free_idx
);

  // first_free[i]: slot i is free and every lower slot is occupied.
  logic [NUM_SLOTS-1:0] first_free;
  logic [NUM_SLOTS-1:0] all_below_busy;

  assign all_below_busy[0] = 1'b1;
  genvar g;
  generate
    for (g = 1; g < NUM_SLOTS; g++) begin : g_chain
      assign all_below_busy[g] = all_below_busy[g-1] & occ[g-1];
    end
    for (g = 0; g < NUM_SLOTS; g++) begin : g_first
      assign first_free[g] = all_below_busy[g] & ~occ[g];
    end
  endgenerate

  always_comb begin
    found    = |first_free;
    free_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (first_free[i]) free_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/slot_occupancy.sv
module slot_occupancy #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_SLOTS-1:0] occ
);

  // Slot 0 is held by the host bridge from reset onward.
  localparam logic [NUM_SLOTS-1:0] RESET_MAP = NUM_SLOTS'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= RESET_MAP;
    end else begin
      if (set_en) occ[set_idx] <= 1'b1;
      if (clr_en) occ[clr_idx] <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_alloc_top.sv
module slot_alloc_top
  import slot_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int REQ_W     = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             claim_req,
  input  logic             release_req,
  input  logic [REQ_W-1:0] req_idx,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [IDX_W-1:0] rsp_idx
);

  slot_op_e             op;
  logic                 in_range;
  logic [IDX_W-1:0]     slot_idx;
  logic [NUM_SLOTS-1:0] occ;
  logic                 found;
  logic [IDX_W-1:0]     free_idx;

  // Named events for the checker.
  logic                 req_any;
  logic                 op_multi;
  logic                 op_alloc;
  logic                 set_en;
  logic [IDX_W-1:0]     set_idx;
  logic                 clr_en;
  slot_status_e         nxt_status;
  logic [IDX_W-1:0]     nxt_idx;

  slot_req_decode #(.NUM_SLOTS(NUM_SLOTS), .REQ_W(REQ_W)) u_dec (
    .alloc_req  (alloc_req),
    .claim_req  (claim_req),
    .release_req(release_req),
    .req_idx    (req_idx),
    .op         (op),
    .in_range   (in_range),
    .slot_idx   (slot_idx)
  );

  slot_lowest_free #(.NUM_SLOTS(NUM_SLOTS)) u_scan (
    .occ     (occ),
    .found   (found),
    .free_idx(free_idx)
  );

  slot_occupancy #(.NUM_SLOTS(NUM_SLOTS)) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (set_en),
    .set_idx(set_idx),
    .clr_en (clr_en),
    .clr_idx(slot_idx),
    .occ    (occ)
  );

  assign req_any  = (op != OP_IDLE);
  assign op_multi = (op == OP_MULTI);
  assign op_alloc = (op == OP_ALLOC);

  always_comb begin
    set_en     = 1'b0;
    set_idx    = slot_idx;
    clr_en     = 1'b0;
    nxt_status = ST_INVALID;
    nxt_idx    = '0;
    unique case (op)
      OP_ALLOC: begin
        if (found) begin
          set_en     = 1'b1;
          set_idx    = free_idx;
          nxt_status = ST_OK;
          nxt_idx    = free_idx;
        end else begin
          nxt_status = ST_NONE_FREE;
        end
      end
      OP_CLAIM: begin
        if (!in_range) begin
          nxt_status = ST_INVALID;
        end else if (occ[slot_idx]) begin
          nxt_status = ST_IN_USE;
        end else begin
          set_en     = 1'b1;
          nxt_status = ST_OK;
          nxt_idx    = slot_idx;
        end
      end
      OP_RELEASE: begin
        if (in_range) begin
          clr_en     = 1'b1;
          nxt_status = ST_OK;
          nxt_idx    = slot_idx;
        end
      end
      OP_MULTI: nxt_status = ST_INVALID;
      default:  nxt_status = ST_INVALID;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 2'd0;
      rsp_idx    <= '0;
    end else begin
      rsp_valid <= req_any;
      if (req_any) begin
        rsp_status <= nxt_status;
        rsp_idx    <= nxt_idx;
      end
    end
  end

endmodule

// File: rtl/slot_alloc_checker.sv
module slot_alloc_checker #(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_any,
  input logic                 op_multi,
  input logic                 op_alloc,
  input logic                 clr_en,
  input logic [NUM_SLOTS-1:0] occ,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_status,
  input logic [IDX_W-1:0]     rsp_idx
);

  logic [NUM_SLOTS-1:0] occ_d;
  logic                 alloc_d;
  logic                 multi_d;
  logic                 clr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_d   <= NUM_SLOTS'(1);
      alloc_d <= 1'b0;
      multi_d <= 1'b0;
      clr_d   <= 1'b0;
    end else begin
      occ_d   <= occ;
      alloc_d <= op_alloc;
      multi_d <= op_multi;
      clr_d   <= clr_en;
    end
  end

  logic [NUM_SLOTS-1:0] below_mask;
  assign below_mask = (NUM_SLOTS'(1) << rsp_idx) - NUM_SLOTS'(1);

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |=> !rsp_valid); // R8
  AST_SLOT0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_d[0] && !occ[0]) |-> clr_d); // R2
  AST_ALLOC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && alloc_d && rsp_status == 2'd0) |->
      (!occ_d[rsp_idx] && occ[rsp_idx] && ((~occ_d & below_mask) == '0))); // R3
  AST_FULL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> ((&occ_d) && occ == occ_d)); // R4
  AST_IN_USE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd3) |-> (occ == occ_d && rsp_idx == '0)); // R6
  AST_MULTI_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && multi_d) |-> (occ == occ_d && rsp_status == 2'd2)); // R9
  AST_INVALID_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd2) |-> (occ == occ_d && rsp_idx == '0)); // R5

endmodule

bind slot_alloc_top slot_alloc_checker #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_any   (req_any),
  .op_multi  (op_multi),
  .op_alloc  (op_alloc),
  .clr_en    (clr_en),
  .occ       (occ),
  .rsp_valid (rsp_valid),
  .rsp_status(rsp_status),
  .rsp_idx   (rsp_idx)
);

// File: tb/slot_alloc_top_test.sv
module slot_alloc_top_test;
  localparam int N     = 32;
  localparam int REQ_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             alloc_req = 1'b0;
  logic             claim_req = 1'b0;
  logic             release_req = 1'b0;
  logic [REQ_W-1:0] req_idx = '0;
  logic             rsp_valid;
  logic [1:0]       rsp_status;
  logic [4:0]       rsp_idx;

  always #5 clk = ~clk;

  slot_alloc_top uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .claim_req(claim_req),
    .release_req(release_req), .req_idx(req_idx), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_idx(rsp_idx)
  );

  int    tests = 0;
  int    fails = 0;
  bit    model [N];
  logic [6:0] exp_q [$];
  string      tag_q [$];

  task automatic expect_rsp(input logic [1:0] st, input int ix, input string tag);
    exp_q.push_back({st, 5'(ix)});
    tag_q.push_back(tag);
  endtask

  // Drive one cycle of requests and predict the answer from the model.
  task automatic op(input bit a, input bit c, input bit r, input int idx, input string tag);
    @(negedge clk);
    alloc_req = a; claim_req = c; release_req = r; req_idx = REQ_W'(idx);
    if (int'(a) + int'(c) + int'(r) > 1) begin
      expect_rsp(2'd2, 0, tag);
    end else if (a) begin
      int pick = -1;
      for (int i = N - 1; i >= 0; i--) if (!model[i]) pick = i;
      if (pick >= 0) begin model[pick] = 1'b1; expect_rsp(2'd0, pick, tag); end
      else expect_rsp(2'd1, 0, tag);
    end else if (c) begin
      if (idx >= N) expect_rsp(2'd2, 0, tag);
      else if (model[idx]) expect_rsp(2'd3, 0, tag);
      else begin model[idx] = 1'b1; expect_rsp(2'd0, idx, tag); end
    end else if (r) begin
      if (idx >= N) expect_rsp(2'd2, 0, tag);
      else begin model[idx] = 1'b0; expect_rsp(2'd0, idx, tag); end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      alloc_req = 0; claim_req = 0; release_req = 0; req_idx = '0;
    end
  endtask

  // Monitor: each response is compared against the oldest prediction.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected response: actual=%0d/%0d expected=none", rsp_status, rsp_idx);
      end else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_status, rsp_idx} !== e) begin
          fails++;
          $display("FAIL %s: actual status=%0d idx=%0d expected status=%0d idx=%0d",
                   t, rsp_status, rsp_idx, e[6:5], e[4:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    model[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 reset response: actual=%0d expected=0", rsp_valid);
    end
    op(0, 1, 0, 0, "R2 claim of reserved slot 0");
    op(1, 0, 0, 0, "R3 first allocation");
    op(0, 1, 0, 7, "R6 claim free slot 7");
    op(0, 1, 0, 7, "R6 reclaim slot 7");
    for (int k = 0; k < 29; k++) op(1, 0, 0, 0, "R3 fill allocation");
    op(1, 0, 0, 0, "R4 allocation when full");
    op(1, 0, 0, 0, "R4 second allocation when full");
    op(0, 0, 1, 5, "R7 release slot 5");
    op(1, 0, 0, 0, "R3 allocation reuses slot 5");
    op(0, 1, 0, 32, "R1 claim index 32");
    op(0, 1, 0, 200, "R5 claim index 200");
    op(0, 1, 0, 31, "R1 claim occupied slot 31");
    op(0, 0, 1, 31, "R1 release slot 31");
    idle(1);
    op(0, 1, 0, 31, "R1 claim freed slot 31");
    op(0, 0, 1, 33, "R7 release index 33");
    op(0, 0, 1, 10, "R7 release slot 10");
    op(0, 0, 1, 10, "R7 release free slot 10 again");
    op(1, 1, 0, 3, "R9 alloc and claim together");
    op(0, 1, 1, 10, "R9 claim and release together");
    op(1, 1, 1, 4, "R9 all three together");
    op(1, 0, 0, 0, "R9 slot 10 still lowest free");
    op(0, 0, 1, 0, "R7 release slot 0");
    op(0, 0, 1, 12, "R7 release slot 12");
    op(1, 0, 0, 0, "R3 allocation returns slot 0");
    op(1, 0, 0, 0, "R3 allocation returns slot 12");
    idle(3);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 missing responses: actual=%0d pending expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule